// File: doc/BRIEF.md
# Unit-Select ALU with Shifter

This block is the combinational execution stage of a single-cycle processor. It takes two 32-bit operands and returns one 32-bit result with a zero flag. Three sub-units compute in parallel, and a 2-bit unit select picks which one drives the result. The sub-units are an adder/subtractor, a bitwise logic unit and a barrel shifter. The fourth select value forces the result to zero.

The logic unit is not driven by an opcode. Its 4-bit function code is a truth table: for each bit position, the two operand bits pick one of the four code bits. Any two-input bitwise function can therefore be issued. The shifter moves operand A by a 5-bit amount, left or right. It can shift logically, shift arithmetically, rotate, or pass A through untouched.

Top module: `exec_unit`

## Requirements
- R1: The unit select chooses the result source: 00 selects the arithmetic unit, 01 the logic unit and 10 the shifter.
- R2: With the subtract control low, the arithmetic unit returns A + B modulo 2^32.
- R3: With the subtract control high, the arithmetic unit returns A - B in two's complement, modulo 2^32.
- R4: Each logic result bit i equals function-code bit number {~A[i], ~B[i]}, where ~A[i] is the upper index bit. So 0001 gives AND, 0110 XOR, 0111 OR, 1000 NOR, 0011 passes A and 0101 passes B.
- R5: All 16 logic function codes are honoured, including the two constant codes: 0000 gives all zeros and 1111 gives all ones.
- R6: Shift type 00 (no shift) returns operand A unchanged, whatever the shift amount and direction.
- R7: Shift type 01 (logical) moves A by 0 to 31 positions and fills with zeros. The direction bit is 0 for left and 1 for right.
- R8: Shift type 10 (arithmetic) fills with copies of A[31] when shifting right. Shifting left gives the same result as a logical left shift.
- R9: Shift type 11 (rotate) wraps the bits that leave one end of A back in at the other end, in the chosen direction.
- R10: Unit select 11 drives the result to zero, whatever the other inputs are.
- R11: The zero flag is high exactly when the 32-bit result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand A; also the value that the shifter moves |
| opnd_b | input | 32 | Operand B |
| shamt | input | 5 | Shift or rotate amount, 0 to 31 |
| unit_sel | input | 2 | Result source: 00 arithmetic, 01 logic, 10 shifter, 11 off |
| lfunc | input | 4 | Truth-table code for the logic unit |
| sh_type | input | 2 | 00 none, 01 logical, 10 arithmetic, 11 rotate |
| sh_right | input | 1 | Shift direction: 0 left, 1 right |
| sub_en | input | 1 | 1 selects subtraction in the arithmetic unit |
| result | output | 32 | Selected result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the block with its default 32-bit data width. With that width the shift amount spans its full range, so every stage of the shifter is exercised. Sign fill and rotate wrap are driven at both 0 and 31 positions. Carry and borrow across all 32 bits are reached with all-ones, zero and sign-boundary operands. Every one of the 16 logic codes and every unit, type and direction encoding is swept against bench reference functions, on both random and directed operands.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;
  typedef enum logic [1:0] {
    SEL_ARITH = 2'b00,
    SEL_LOGIC = 2'b01,
    SEL_SHIFT = 2'b10,
    SEL_OFF   = 2'b11
  } unit_sel_e;

  typedef enum logic [1:0] {
    SHK_NONE  = 2'b00,
    SHK_LOGIC = 2'b01,
    SHK_ARITH = 2'b10,
    SHK_ROT   = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/xu_addsub.sv
module xu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] y
);
  logic [W-1:0] b_eff;

  always_comb begin
    b_eff = b ^ {W{sub}};
  end

  // two's complement: invert B and inject the carry-in
  assign y = a + b_eff + {{(W-1){1'b0}}, sub};
endmodule

// File: rtl/xu_logic.sv
module xu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   func,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // each bit is a 4:1 lookup into the truth-table code
    assign y[i] = func[{~a[i], ~b[i]}];
  end
endmodule

// File: rtl/xu_shifter.sv
module xu_shifter
  import exec_unit_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  shift_kind_e   kind,
  input  logic          right,
  output logic [W-1:0]  dout
);
  function automatic logic [W-1:0] bit_rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  logic [W-1:0] stg [SW+1];
  logic         fill_bit;
  logic         wrap;
  logic [W-1:0] core_out;

  // left shifts reuse the right-shift network on a bit-reversed word
  assign stg[0]   = right ? din : bit_rev(din);
  assign fill_bit = (kind == SHK_ARITH) && right && din[W-1];
  assign wrap     = (kind == SHK_ROT);

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int S = 1 << k;
    logic [W-1:0] moved;
    assign moved      = wrap ? {stg[k][S-1:0], stg[k][W-1:S]}
                             : {{S{fill_bit}}, stg[k][W-1:S]};
    assign stg[k+1]   = amt[k] ? moved : stg[k];
  end

  assign core_out = right ? stg[SW] : bit_rev(stg[SW]);
  assign dout     = (kind == SHK_NONE) ? din : core_out;
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic [1:0]        unit_sel,
  input  logic [3:0]        lfunc,
  input  logic [1:0]        sh_type,
  input  logic              sh_right,
  input  logic              sub_en,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  logic [DATA_W-1:0] arith_y;
  logic [DATA_W-1:0] logic_y;
  logic [DATA_W-1:0] shift_y;
  unit_sel_e         sel;
  shift_kind_e       kind;

  assign sel  = unit_sel_e'(unit_sel);
  assign kind = shift_kind_e'(sh_type);

  xu_addsub #(.W(DATA_W)) i_addsub (
    .a  (opnd_a),
    .b  (opnd_b),
    .sub(sub_en),
    .y  (arith_y)
  );

  xu_logic #(.W(DATA_W)) i_logic (
    .a   (opnd_a),
    .b   (opnd_b),
    .func(lfunc),
    .y   (logic_y)
  );

  xu_shifter #(.W(DATA_W), .SW(SH_W)) i_shifter (
    .din  (opnd_a),
    .amt  (shamt),
    .kind (kind),
    .right(sh_right),
    .dout (shift_y)
  );

  always_comb begin
    unique case (sel)
      SEL_ARITH: result = arith_y;
      SEL_LOGIC: result = logic_y;
      SEL_SHIFT: result = shift_y;
      default:   result = '0;
    endcase
  end

  assign zero = ~|result;
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [SH_W-1:0]   shamt,
  input logic [1:0]        unit_sel,
  input logic [3:0]        lfunc,
  input logic [1:0]        sh_type,
  input logic              sh_right,
  input logic              sub_en,
  input logic [DATA_W-1:0] result,
  input logic              zero
);
  logic known;
  assign known = !$isunknown({opnd_a, opnd_b, shamt, unit_sel, lfunc,
                              sh_type, sh_right, sub_en});

  always @* begin
    if (known) begin
      if (unit_sel == 2'b11)
        AST_OFF_IS_ZERO: assert (result == '0 && zero); // R10
      if (unit_sel == 2'b00 && sub_en && opnd_a == opnd_b)
        AST_SELF_SUB_ZERO: assert (zero); // R11
      if (unit_sel == 2'b00 && !sub_en && opnd_b == '0)
        AST_ADD_ZERO_ID: assert (result == opnd_a); // R2
      if (unit_sel == 2'b01 && lfunc == 4'b0011)
        AST_LOGIC_PASS_A: assert (result == opnd_a); // R4
      if (unit_sel == 2'b01 && lfunc == 4'b1111)
        AST_LOGIC_ONES: assert (&result); // R5
      if (unit_sel == 2'b10 && sh_type == 2'b00)
        AST_NOSHIFT_PASS: assert (result == opnd_a); // R6
      if (unit_sel == 2'b10 && sh_type == 2'b11)
        AST_ROT_KEEPS_ONES: assert ($countones(result) == $countones(opnd_a)); // R9
      if (unit_sel == 2'b10 && sh_type == 2'b10 && sh_right)
        AST_ASR_SIGN: assert (result[DATA_W-1] == opnd_a[DATA_W-1]); // R8
    end
  end
endmodule

bind exec_unit exec_unit_chk #(.DATA_W(DATA_W), .SH_W(SH_W)) i_exec_unit_chk (
  .opnd_a  (opnd_a),
  .opnd_b  (opnd_b),
  .shamt   (shamt),
  .unit_sel(unit_sel),
  .lfunc   (lfunc),
  .sh_type (sh_type),
  .sh_right(sh_right),
  .sub_en  (sub_en),
  .result  (result),
  .zero    (zero)
);

// File: tb/test_exec_unit.sv
`timescale 1ns/1ps
module test_exec_unit;
  logic        clk;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  shamt;
  logic [1:0]  unit_sel;
  logic [3:0]  lfunc;
  logic [1:0]  sh_type;
  logic        sh_right;
  logic        sub_en;
  logic [31:0] result;
  logic        zero;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  exec_unit i_exec_unit (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt), .unit_sel(unit_sel),
    .lfunc(lfunc), .sh_type(sh_type), .sh_right(sh_right), .sub_en(sub_en),
    .result(result), .zero(zero)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] ref_logic(input logic [31:0] a, b, input logic [3:0] f);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = f[(a[i] ? 0 : 2) + (b[i] ? 0 : 1)];
    return r;
  endfunction

  function automatic logic [31:0] ref_shift(input logic [31:0] a, input logic [4:0] n,
                                             input logic [1:0] t, input logic rt);
    case (t)
      2'b00: return a;
      2'b01: return rt ? (a >> n) : (a << n);
      2'b10: return rt ? 32'($signed(a) >>> n) : (a << n);
      default:
        if (n == 0) return a;
        else if (rt) return (a >> n) | (a << (32 - n));
        else return (a << n) | (a >> (32 - n));
    endcase
  endfunction

  function automatic logic [31:0] ref_all(input logic [31:0] a, b, input logic [4:0] n,
      input logic [1:0] u, input logic [3:0] f, input logic [1:0] t, input logic rt, s);
    case (u)
      2'b00: return s ? a - b : a + b;
      2'b01: return ref_logic(a, b, f);
      2'b10: return ref_shift(a, n, t, rt);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (u=%b f=%b t=%b r=%b s=%b n=%0d a=%h b=%h)",
               tag, got, exp, unit_sel, lfunc, sh_type, sh_right, sub_en, shamt, opnd_a, opnd_b);
    end
  endtask

  function automatic string tag_of(input logic [1:0] u, t, input logic s, input logic [3:0] f);
    case (u)
      2'b00: return s ? "R3" : "R2";
      2'b01: return (f == 4'b0000 || f == 4'b1111) ? "R5" : "R4";
      2'b10: case (t)
               2'b00: return "R6";
               2'b01: return "R7";
               2'b10: return "R8";
               default: return "R9";
             endcase
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, b, input logic [4:0] n, input logic [1:0] u,
                       input logic [3:0] f, input logic [1:0] t, input logic rt, s);
    logic [31:0] exp;
    @(posedge clk);
    opnd_a = a; opnd_b = b; shamt = n; unit_sel = u;
    lfunc = f; sh_type = t; sh_right = rt; sub_en = s;
    @(negedge clk);
    exp = ref_all(a, b, n, u, f, t, rt, s);
    check(tag_of(u, t, s, f), result, exp);
    check("R11", {31'h0, zero}, {31'h0, exp == 32'h0});
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] corners [8];
    void'($urandom(32'd4242));
    corners[0] = 32'h0000_0000; corners[1] = 32'hFFFF_FFFF;
    corners[2] = 32'h8000_0000; corners[3] = 32'h7FFF_FFFF;
    corners[4] = 32'h0000_0001; corners[5] = 32'hA5A5_5A5A;
    corners[6] = 32'hF0F0_0F0F; corners[7] = 32'h8000_0001;

    // R1: one operand pair through the first three selects, then the disabled select
    apply(32'h0000_000C, 32'h0000_000A, 5'd1, 2'b00, 4'b0001, 2'b01, 1'b0, 1'b0);
    check("R1", result, 32'h16);
    apply(32'h0000_000C, 32'h0000_000A, 5'd1, 2'b01, 4'b0001, 2'b01, 1'b0, 1'b0);
    check("R1", result, 32'h08);
    apply(32'h0000_000C, 32'h0000_000A, 5'd1, 2'b10, 4'b0001, 2'b01, 1'b0, 1'b0);
    check("R1", result, 32'h18);
    apply(32'hFFFF_FFFF, 32'h1234_5678, 5'd7, 2'b11, 4'b1111, 2'b11, 1'b1, 1'b1);
    check("R10", result, 32'h0);
    check("R11", {31'h0, zero}, 32'h1);

    // R2 and R3: carry and borrow across the full word
    apply(32'hFFFF_FFFF, 32'h0000_0001, 5'd0, 2'b00, 4'b0, 2'b0, 1'b0, 1'b0);
    check("R2", result, 32'h0);
    apply(32'h0000_0000, 32'h0000_0001, 5'd0, 2'b00, 4'b0, 2'b0, 1'b0, 1'b1);
    check("R3", result, 32'hFFFF_FFFF);
    apply(32'h8000_0000, 32'h0000_0001, 5'd0, 2'b00, 4'b0, 2'b0, 1'b0, 1'b1);
    check("R3", result, 32'h7FFF_FFFF);

    // R4 and R5: every code over corner operand pairs
    for (int f = 0; f < 16; f++)
      for (int i = 0; i < 8; i++)
        apply(corners[i], corners[7-i], 5'd0, 2'b01, 4'(f), 2'b00, 1'b0, 1'b0);

    // R6 to R9: every type, direction and amount on corner operands
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int n = 0; n < 32; n++)
          for (int i = 1; i < 8; i += 2)
            apply(corners[i], 32'h0, 5'(n), 2'b10, 4'b0, 2'(t), d[0], 1'b0);

    // R8: directed sign fill and left equivalence
    apply(32'h8000_0000, 32'h0, 5'd31, 2'b10, 4'b0, 2'b10, 1'b1, 1'b0);
    check("R8", result, 32'hFFFF_FFFF);
    apply(32'h4000_0001, 32'h0, 5'd1, 2'b10, 4'b0, 2'b10, 1'b0, 1'b0);
    check("R8", result, 32'h8000_0002);
    // R9: directed wrap
    apply(32'h8000_0001, 32'h0, 5'd1, 2'b10, 4'b0, 2'b11, 1'b0, 1'b0);
    check("R9", result, 32'h0000_0003);
    apply(32'h8000_0001, 32'h0, 5'd1, 2'b10, 4'b0, 2'b11, 1'b1, 1'b0);
    check("R9", result, 32'hC000_0000);
    // R7: zero fill both ways at the far end
    apply(32'hFFFF_FFFF, 32'h0, 5'd31, 2'b10, 4'b0, 2'b01, 1'b1, 1'b0);
    check("R7", result, 32'h1);
    apply(32'hFFFF_FFFF, 32'h0, 5'd31, 2'b10, 4'b0, 2'b01, 1'b0, 1'b0);
    check("R7", result, 32'h8000_0000);

    // random mix over all encodings
    for (int k = 0; k < 3000; k++)
      apply($urandom, ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom, 5'($urandom),
            2'($urandom), 4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));

    done = 1;
    summary();
  end
endmodule